// File: doc/BRIEF.md
# Input-Change Interrupt Generator

This block raises an active-low interrupt request whenever a pin that is set up as an input no longer matches the level last captured for it. The pins are split into ports of equal width. Each port keeps a snapshot of its pin levels, and that snapshot is refreshed only when the surrounding register logic reports a read of that port's input register. A read strobe arrives as a one-cycle capture pulse, timed to the acknowledge of the read byte.

A mismatch therefore clears in one of two ways. The pin can return to its captured level, or its port can be read. Each port clears on its own, so reading one port leaves a pending change on another port in place. Pins set up as outputs are masked out. When a pin is switched from output to input while its level differs from its snapshot, the interrupt is raised. The request is registered, so the open-drain pad driver sees a stable level. The pad drives low while `irq_no` is 0 and releases the line otherwise.

On the first clock edge after reset is released, every snapshot loads the present pin levels, so no interrupt is pending when operation begins.

Top module: `chg_irq_gen`

## Requirements
- R1: While `rst_ni` is low, `snap_o` is all zeros and `irq_no` is 1. On the first rising edge after release, `snap_o` loads `pin_i` for every port and `irq_no` stays 1.
- R2: If a pin with `dir_in_i` bit = 1 (1 = input) differs from its `snap_o` bit, `irq_no` reads 0 after the next rising edge.
- R3: A pin with `dir_in_i` bit = 0 (output) never drives `irq_no` low, whatever its level.
- R4: When every input pin again equals its snapshot bit, `irq_no` returns to 1 after the next rising edge, with no capture needed.
- R5: A 1 on `cap_i[p]` at a rising edge loads `pin_i[p*PORT_W +: PORT_W]` into the same slice of `snap_o`. This removes that port's share of the interrupt in the same edge. Port 0 is bits 7:0 and port 1 is bits 15:8.
- R6: A capture on one port leaves another port's snapshot slice and pending mismatch untouched.
- R7: If a pin's `dir_in_i` bit changes from 0 to 1 while its level differs from its snapshot bit, `irq_no` goes to 0 after the next rising edge.
- R8: After the first edge following reset, a snapshot slice holds its value at every edge where its `cap_i` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | PORT_W*PORT_CNT | Synchronised pin levels |
| dir_in_i | input | PORT_W*PORT_CNT | Direction per pin, 1 = input, 0 = output |
| cap_i | input | PORT_CNT | One-cycle capture strobe per port, issued on an input-register read |
| irq_no | output | 1 | Interrupt request, active low, registered |
| snap_o | output | PORT_W*PORT_CNT | Captured input snapshots of all ports |

## Verification
The properties assume that `pin_i` is already synchronised to `clk_i` and that each `cap_i` bit is a clean one-cycle pulse sampled on the rising edge. They also assume that the direction bits are stable across each edge. The properties compare `irq_no` with the snapshot seen after an edge and with the pin and direction values from before that edge. For this to hold, the inputs may change only between edges. The stimulus keeps to this by driving every input on the falling edge and issuing each capture pulse for exactly one cycle. It also holds pins steady across the edge where reset is released.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int unsigned DEF_PORT_W   = 8;
  localparam int unsigned DEF_PORT_CNT = 2;
endpackage

// File: rtl/chg_port_snap.sv
module chg_port_snap #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         prime_i,
  input  logic         cap_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] snap_o,
  output logic [W-1:0] snap_d_o
);
  logic [W-1:0] snap_q;

  // first edge after reset primes the snapshot with live pins
  assign snap_d_o = (prime_i || cap_i) ? pin_i : snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= snap_d_o;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/chg_port_cmp.sv
module chg_port_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_in_i,
  input  logic [W-1:0] snap_i,
  output logic         diff_o
);
  logic [W-1:0] diff_bits;

  always_comb begin
    for (int i = 0; i < W; i++) diff_bits[i] = dir_in_i[i] & (pin_i[i] ^ snap_i[i]);
  end

  assign diff_o = |diff_bits;
endmodule

// File: rtl/chg_irq_gen.sv
module chg_irq_gen
  import chg_irq_pkg::*;
#(
  parameter int unsigned PORT_W   = DEF_PORT_W,
  parameter int unsigned PORT_CNT = DEF_PORT_CNT,
  localparam int unsigned PIN_W   = PORT_W * PORT_CNT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PIN_W-1:0]    pin_i,
  input  logic [PIN_W-1:0]    dir_in_i,
  input  logic [PORT_CNT-1:0] cap_i,
  output logic                irq_no,
  output logic [PIN_W-1:0]    snap_o
);
  logic                primed_q;
  logic                irq_q;
  logic [PORT_CNT-1:0] port_diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
    logic [PORT_W-1:0] snap_d;

    chg_port_snap #(.W(PORT_W)) u_snap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .prime_i  (!primed_q),
      .cap_i    (cap_i[p]),
      .pin_i    (pin_i[p*PORT_W +: PORT_W]),
      .snap_o   (snap_o[p*PORT_W +: PORT_W]),
      .snap_d_o (snap_d)
    );

    // compare against the next snapshot so a capture clears in the same edge
    chg_port_cmp #(.W(PORT_W)) u_cmp (
      .pin_i    (pin_i[p*PORT_W +: PORT_W]),
      .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
      .snap_i   (snap_d),
      .diff_o   (port_diff[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |port_diff;
  end

  assign irq_no = ~irq_q;
endmodule

// File: rtl/chg_irq_gen_chk.sv
module chg_irq_gen_chk #(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned PORT_CNT = 2,
  localparam int unsigned PIN_W   = PORT_W * PORT_CNT
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [PIN_W-1:0]    pin_i,
  input logic [PIN_W-1:0]    dir_in_i,
  input logic [PORT_CNT-1:0] cap_i,
  input logic                irq_no,
  input logic [PIN_W-1:0]    snap_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_idle: assert (irq_no && snap_o == '0);
  end

  a_r1_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_q |=> (irq_no && snap_o == $past(pin_i)));

  // R2, R3, R4, R7: request equals the masked mismatch seen after the edge
  a_r2_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q |=> (irq_no == !(|(($past(pin_i) ^ snap_o) & $past(dir_in_i)))));

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_chk
    a_r5_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i[p] |=> (snap_o[p*PORT_W +: PORT_W] == $past(pin_i[p*PORT_W +: PORT_W])));

    a_r8_snap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && !cap_i[p]) |=> $stable(snap_o[p*PORT_W +: PORT_W]));
  end
endmodule

bind chg_irq_gen chg_irq_gen_chk #(.PORT_W(PORT_W), .PORT_CNT(PORT_CNT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_i    (pin_i),
  .dir_in_i (dir_in_i),
  .cap_i    (cap_i),
  .irq_no   (irq_no),
  .snap_o   (snap_o)
);

// File: tb/chg_irq_gen_tb.sv
module chg_irq_gen_tb;
  localparam int PW = 8;
  localparam int PC = 2;
  localparam int N  = PW * PC;

  typedef struct {
    logic [N-1:0] snap;
    logic         irq_n;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pin = '0;
  logic [N-1:0]  dir = '1;
  logic [PC-1:0] cap = '0;
  logic          irq_no;
  logic [N-1:0]  snap_o;

  exp_t         q[$];
  logic [N-1:0] m_snap = '0;
  logic         m_primed = 1'b0;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  chg_irq_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .dir_in_i(dir),
    .cap_i(cap), .irq_no(irq_no), .snap_o(snap_o)
  );

  // model of one rising edge with the inputs now driven
  task automatic push(input string tag);
    exp_t e;
    if (!m_primed) m_snap = pin;
    else
      for (int p = 0; p < PC; p++)
        if (cap[p]) m_snap[p*PW +: PW] = pin[p*PW +: PW];
    m_primed = 1'b1;
    e.snap  = m_snap;
    e.irq_n = ~(|((pin ^ m_snap) & dir));
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic [N-1:0] p_v, input logic [N-1:0] d_v,
                      input logic [PC-1:0] c_v, input string tag);
    @(negedge clk);
    pin = p_v; dir = d_v; cap = c_v;
    push(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (snap_o !== e.snap || irq_no !== e.irq_n) begin
          n_fail++;
          $display("FAIL %s: snap=%h irq_n=%b expected snap=%h irq_n=%b",
                   e.tag, snap_o, irq_no, e.snap, e.irq_n);
        end
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [N-1:0] p;
    pin = 16'hA5C3;
    repeat (3) @(negedge clk);
    n_run++;
    if (snap_o !== '0 || irq_no !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: snap=%h irq_n=%b expected snap=0000 irq_n=1", snap_o, irq_no);
    end
    @(negedge clk); rst_ni = 1'b1; push("R1 prime");

    p = 16'hA5C3;
    step(p, '1, 2'b00, "R8 idle hold");
    p[3] = ~p[3];
    step(p, '1, 2'b00, "R2 input change");
    p[3] = ~p[3];
    step(p, '1, 2'b00, "R4 return clears");
    p[5] = ~p[5];
    step(p, 16'hFFDF, 2'b00, "R3 output masked");
    step(p, '1, 2'b00, "R7 output to input");
    step(p, '1, 2'b01, "R5 port0 capture");
    p[9] = ~p[9]; p[2] = ~p[2];
    step(p, '1, 2'b00, "R2 two ports");
    step(p, '1, 2'b01, "R6 port0 read keeps port1");
    step(p, '1, 2'b00, "R8 hold after read");
    step(p, '1, 2'b10, "R5 port1 capture clears");
    p[12] = ~p[12];
    step(p, '1, 2'b01, "R6 port0 read keeps port1 bit12");
    p[12] = ~p[12];
    step(p, '1, 2'b00, "R4 port1 return");
    p[0] = ~p[0];
    step(p, '1, 2'b10, "R6 port1 read keeps port0");
    step(p, '1, 2'b01, "R5 port0 clears");
    for (int i = 0; i < 6; i++) begin
      p = p ^ (16'h1 << (i * 3));
      step(p, '0, 2'b00, "R3 all outputs");
    end
    step(p, 16'h00FF, 2'b00, "R7 port0 to input");
    step(p, 16'h00FF, 2'b11, "R5 both capture");
    p = ~p;
    step(p, 16'hFF00, 2'b01, "R6 port0 read, port1 mismatch");
    step(p, 16'hFF00, 2'b10, "R5 port1 capture");
    step(p, 16'hFFFF, 2'b00, "R7 port0 back to input");
    step(p, 16'hFFFF, 2'b11, "R5 clear all");
    step(p, 16'hFFFF, 2'b00, "R8 final hold");

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule